// File: doc/BRIEF.md
# Word-Parallel CRC Engine

This block advances a degree-M cyclic redundancy check by W message bits in every clock cycle. W must divide M and may be smaller than M. The update is linear over GF(2). Each next-state bit is the XOR of the current state bits picked out by one row of a stepping matrix, combined with the incoming word. The stepping matrix equals W serial shift steps folded into one. The block receives this matrix on a flat input bus and does not derive it, so one engine serves any generator polynomial. The matrix normally comes from a constant or from a separate generator block.

Two forms of the update are available, chosen cycle by cycle with a mode pin.

- **Augmented form:** the word is XORed into the low end of the state after the matrix step. A message followed by M zero bits then leaves the check value in the state.
- **Direct form:** the word is XORed into the top end of the state before the matrix step. The check value is then ready as soon as the last message word is absorbed, with no zero padding.

A clear input zeroes the state, and the state holds in any cycle without a valid word.

Top module: `crc_par_engine`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `crc_o` is all zeros.
- R2: A cycle with `clr` high leaves `crc_o` zero at the next edge, even when `vld` is high in that same cycle (clear wins).
- R3: In a cycle with `clr` and `vld` both low, `crc_o` keeps its value whatever `data_i`, `mode` and `mat_i` do.
- R4: The matrix bus holds the coefficient of current state bit j in next state bit i at `mat_i[i*M + j]`. Row i is therefore the slice `mat_i[i*M +: M]`.
- R5: With `mode` = 0 (augmented), an accepted word updates the state to `F·X XOR D`. Here D carries `data_i` in bits W-1..0, and `data_i[W-1]` is the earliest message bit. From a zero state, one word therefore leaves `crc_o` equal to `data_i` zero-extended.
- R6: With `mode` = 1 (direct), an accepted word updates the state to `F·(X XOR D)`. Here D carries `data_i` in bits M-1..M-W, and `data_i[W-1]` lands on bit M-1.
- R7: In augmented mode, with `mat_i` set to W serial steps of the polynomial, feeding a message followed by M zero bits leaves the standard unreflected, zero-initialised CRC in `crc_o`. For generator 0x8005 and the ASCII string "123456789", this value is 0xFEE8.
- R8: In direct mode, with the same matrix, the unpadded message gives the same CRC as R7. For any message length that is a multiple of W, both modes match a bit-serial shift register of the same form.
- R9: When W < M, state bits that the word does not reach get no data term. In augmented mode, bits M-1..W are driven only by the matrix product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the state to zero, has priority over `vld` |
| vld | input | 1 | Absorb `data_i` this cycle |
| mode | input | 1 | 0 = augmented form, 1 = direct form |
| mat_i | input | M*M | Stepping matrix, row i at `[i*M +: M]`, bit j = coefficient of state bit j |
| data_i | input | W | Message word, bit W-1 first in time |
| crc_o | output | M | Current state / check value |

## Verification
The two functions of this block that can fall in one cycle are clear and word absorption.

The bench holds the state at a non-zero value and raises `clr` and `vld` together, with a non-zero word that would otherwise change the state. The state must read zero afterwards, which shows the clear won and the word was dropped.

A second collision sets the mode and the matrix to values that give a known result if the word were taken, and raises `vld` with `clr` low. The result is compared against a bit-serial model, and the bench checks that a later cycle with `vld` low leaves it in place.

// File: rtl/crc_par_pkg.sv
package crc_par_pkg;

    // Where the message word enters the state relative to the matrix step.
    typedef enum logic {
        MODE_AUG = 1'b0,   // XOR after the step, into the low W bits
        MODE_DIR = 1'b1    // XOR before the step, into the high W bits
    } crc_mode_e;

endpackage

// File: rtl/crc_par_place.sv
// Positions the message word according to the selected form.
// vec_pre is what the matrix multiplies; vec_post is XORed after it.
module crc_par_place #(
    parameter int M = 16,
    parameter int W = 8
) (
    input  crc_par_pkg::crc_mode_e mode,
    input  logic [M-1:0]           state,
    input  logic [W-1:0]           data,
    output logic [M-1:0]           vec_pre,
    output logic [M-1:0]           vec_post
);
    import crc_par_pkg::*;

    localparam int PAD = M - W;

    logic [M-1:0] d_low;
    logic [M-1:0] d_high;

    generate
        if (PAD > 0) begin : g_pad
            assign d_low  = {{PAD{1'b0}}, data};
            assign d_high = {data, {PAD{1'b0}}};
        end else begin : g_full
            assign d_low  = data;
            assign d_high = data;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_AUG: begin
                vec_pre  = state;
                vec_post = d_low;
            end
            MODE_DIR: begin
                vec_pre  = state ^ d_high;
                vec_post = '0;
            end
            default: begin
                vec_pre  = state;
                vec_post = '0;
            end
        endcase
    end

endmodule

// File: rtl/crc_par_gf2mv.sv
// GF(2) matrix-vector product: out[i] = XOR_j (mat[i*M+j] AND vec[j]).
module crc_par_gf2mv #(
    parameter int M = 16
) (
    input  logic [M*M-1:0] mat,
    input  logic [M-1:0]   vec,
    output logic [M-1:0]   prod
);
    generate
        for (genvar i = 0; i < M; i++) begin : g_row
            assign prod[i] = ^(mat[i*M +: M] & vec);
        end
    endgenerate
endmodule

// File: rtl/crc_par_state.sv
// State register: asynchronous reset, clear over load, hold otherwise.
module crc_par_state #(
    parameter int M = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [M-1:0] nxt,
    output logic [M-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (load) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/crc_par_engine.sv
module crc_par_engine #(
    parameter int M = 16,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           vld,
    input  logic           mode,
    input  logic [M*M-1:0] mat_i,
    input  logic [W-1:0]   data_i,
    output logic [M-1:0]   crc_o
);
    import crc_par_pkg::*;

    crc_mode_e    mode_e;
    logic [M-1:0] vec_pre;
    logic [M-1:0] vec_post;
    logic [M-1:0] prod;
    logic [M-1:0] nxt;

    assign mode_e = crc_mode_e'(mode);

    crc_par_place #(.M(M), .W(W)) u_place (
        .mode     (mode_e),
        .state    (crc_o),
        .data     (data_i),
        .vec_pre  (vec_pre),
        .vec_post (vec_post)
    );

    crc_par_gf2mv #(.M(M)) u_mv (
        .mat  (mat_i),
        .vec  (vec_pre),
        .prod (prod)
    );

    assign nxt = prod ^ vec_post;

    crc_par_state #(.M(M)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .load  (vld),
        .nxt   (nxt),
        .q     (crc_o)
    );

endmodule

// File: rtl/crc_par_engine_chk.sv
module crc_par_engine_chk #(
    parameter int M = 16,
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         vld,
    input logic         mode,
    input logic [W-1:0] data_i,
    input logic [M-1:0] crc_o
);
    logic [M-1:0] data_ext;
    assign data_ext = M'(data_i);

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> crc_o == '0);

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> crc_o == '0);

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !vld) |=> $stable(crc_o));

    a_r5_aug_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !clr && !mode && crc_o == '0) |=> crc_o == $past(data_ext));

    a_r8_zero_word_zero_state: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !clr && crc_o == '0 && data_i == '0) |=> crc_o == '0);
endmodule

bind crc_par_engine crc_par_engine_chk #(.M(M), .W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .vld    (vld),
    .mode   (mode),
    .data_i (data_i),
    .crc_o  (crc_o)
);

// File: tb/sim_crc_par_engine.sv
module sim_crc_par_engine;
    localparam logic [15:0] POLY = 16'h8005;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic c0 = 0, v0 = 0, md0 = 0;
    logic [7:0] d0 = '0;
    logic [255:0] mat0 = '0;
    logic [15:0] crc0;

    logic c1 = 0, v1 = 0, md1 = 0;
    logic [15:0] d1 = '0;
    logic [255:0] mat1 = '0;
    logic [15:0] crc1;

    int checks = 0;
    int errors = 0;

    crc_par_engine #(.M(16), .W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(c0), .vld(v0), .mode(md0),
        .mat_i(mat0), .data_i(d0), .crc_o(crc0));

    crc_par_engine #(.M(16), .W(16)) u1 (
        .clk(clk), .rst_n(rst_n), .clr(c1), .vld(v1), .mode(md1),
        .mat_i(mat1), .data_i(d1), .crc_o(crc1));

    // Sixteen-step matrix for 0x8005, top row first.
    localparam logic [255:0] F16_LIT = {
        16'hDFFF, 16'h3000, 16'h1800, 16'h0C00, 16'h0600, 16'h0300, 16'h0180, 16'h00C0,
        16'h0060, 16'h0030, 16'h0018, 16'h000C, 16'h8006, 16'h4003, 16'h7FFE, 16'hBFFF};

    localparam int NTV = 6;
    localparam logic        TV_MODE [NTV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam int          TV_LEN  [NTV] = '{2, 2, 8, 8, 6, 4};
    localparam logic [63:0] TV_DATA [NTV] = '{
        64'hDEAD_0000_0000_0000, 64'hBEEF_0000_0000_0000,
        64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF,
        64'hFFFF_FFFF_FFFF_0000, 64'h8000_0001_0000_0000};

    localparam logic [7:0] MSG [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
                                       8'h36, 8'h37, 8'h38, 8'h39};

    function automatic logic [15:0] ser_aug(input logic [15:0] x, input logic d);
        return {x[14:0], d} ^ (x[15] ? POLY : 16'h0000);
    endfunction

    function automatic logic [15:0] ser_dir(input logic [15:0] x, input logic d);
        return {x[14:0], 1'b0} ^ ((x[15] ^ d) ? POLY : 16'h0000);
    endfunction

    function automatic logic [15:0] model(input logic md, input logic [63:0] dat, input int nbits);
        logic [15:0] x = '0;
        for (int b = 0; b < nbits; b++)
            x = md ? ser_dir(x, dat[63-b]) : ser_aug(x, dat[63-b]);
        return x;
    endfunction

    // W serial steps of a degree-m shift register, flattened as R4 states.
    function automatic logic [255:0] fmat_gen(input logic [15:0] poly, input int m, input int w);
        logic [255:0] r = '0;
        logic [15:0] v, mask;
        logic fb;
        mask = (m == 16) ? 16'hFFFF : ((16'd1 << m) - 16'd1);
        for (int j = 0; j < m; j++) begin
            v = 16'd1 << j;
            for (int s = 0; s < w; s++) begin
                fb = v[m-1];
                v = ((v << 1) & mask) ^ (fb ? poly : 16'h0000);
            end
            for (int i = 0; i < m; i++) r[i*m + j] = v[i];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic feed0(input logic md, input logic [63:0] dat, input int nbytes);
        c0 = 1; v0 = 0; tick(); c0 = 0;
        for (int k = 0; k < nbytes; k++) begin
            v0 = 1; md0 = md; d0 = dat[63-8*k -: 8]; tick();
        end
        v0 = 0;
    endtask

    task automatic feed1(input logic md, input logic [63:0] dat, input int nbytes);
        c1 = 1; v1 = 0; tick(); c1 = 0;
        for (int k = 0; k < nbytes/2; k++) begin
            v1 = 1; md1 = md; d1 = dat[63-16*k -: 16]; tick();
        end
        v1 = 0;
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] msgw;
        mat0 = fmat_gen(POLY, 16, 8);
        mat1 = F16_LIT;
        #23 rst_n = 1'b1;
        #1;
        chk("R1 u0 after reset", crc0, 16'h0000);
        chk("R1 u1 after reset", crc1, 16'h0000);

        // R4: bench-derived matrices match the layout of the known values
        chk("R4 F16 row layout hi", fmat_gen(POLY, 16, 16)[255:240], F16_LIT[255:240]);
        chk("R4 F16 full layout", 16'(fmat_gen(POLY, 16, 16) == F16_LIT), 16'h0001);
        chk("R4 degree-4 example", fmat_gen(16'h0009, 4, 4)[15:0], 16'h7CEF);

        // Table walk: both engines against the serial model (R8)
        for (int t = 0; t < NTV; t++) begin
            feed0(TV_MODE[t], TV_DATA[t], TV_LEN[t]);
            chk($sformatf("R8 u0 vector %0d", t), crc0, model(TV_MODE[t], TV_DATA[t], 8*TV_LEN[t]));
            feed1(TV_MODE[t], TV_DATA[t], TV_LEN[t]);
            chk($sformatf("R8 u1 vector %0d", t), crc1, model(TV_MODE[t], TV_DATA[t], 8*TV_LEN[t]));
        end

        // R7: augmented with two zero bytes of padding
        c0 = 1; tick(); c0 = 0;
        for (int k = 0; k < 11; k++) begin
            v0 = 1; md0 = 1'b0; d0 = (k < 9) ? MSG[k] : 8'h00; tick();
        end
        v0 = 0;
        chk("R7 augmented check string", crc0, 16'hFEE8);

        // R8: direct, no padding
        c0 = 1; tick(); c0 = 0;
        for (int k = 0; k < 9; k++) begin
            v0 = 1; md0 = 1'b1; d0 = MSG[k]; tick();
        end
        v0 = 0;
        chk("R8 direct check string", crc0, 16'hFEE8);

        // R3: idle cycles with changing inputs leave the value in place
        v0 = 0; d0 = 8'h5A; md0 = 1'b0; tick();
        d0 = 8'hC3; md0 = 1'b1; mat0 = '1; tick();
        chk("R3 hold with vld low", crc0, 16'hFEE8);
        mat0 = fmat_gen(POLY, 16, 8);

        // R2: clear and valid in the same cycle
        c0 = 1; v0 = 1; d0 = 8'hA7; md0 = 1'b0; tick();
        c0 = 0; v0 = 0;
        chk("R2 clear beats valid", crc0, 16'h0000);

        // R5/R6/R9 with an identity matrix on u0 (W < M)
        for (int i = 0; i < 16; i++) mat0[i*16 + i] = 1'b1;
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) if (i != j) mat0[i*16 + j] = 1'b0;
        v0 = 1; md0 = 1'b1; d0 = 8'hB7; tick();
        chk("R6 direct word at top", crc0, 16'hB700);
        md0 = 1'b0; d0 = 8'hB7; tick();
        chk("R9 augmented word at bottom only", crc0, 16'hB7B7);
        v0 = 0;
        mat0 = fmat_gen(POLY, 16, 8);
        c0 = 1; tick(); c0 = 0;
        v0 = 1; md0 = 1'b0; d0 = 8'h9C; tick(); v0 = 0;
        chk("R5 augmented from zero", crc0, 16'h009C);

        // R4 layout with a rotation and a single-row matrix on u1
        c1 = 1; tick(); c1 = 0;
        v1 = 1; md1 = 1'b0; d1 = 16'hA5C3; tick();
        chk("R5 full-width word from zero", crc1, 16'hA5C3);
        mat1 = '0;
        for (int i = 0; i < 16; i++) mat1[i*16 + ((i+1) % 16)] = 1'b1;
        d1 = 16'h0000; tick();
        chk("R4 rotation matrix", crc1, 16'hD2E1);
        mat1 = 256'h000F; tick();
        chk("R4 single row parity", crc1, 16'h0001);
        v1 = 0;

        // R8: u1 direct over eight bytes of the check string
        mat1 = F16_LIT;
        msgw = '0;
        for (int k = 0; k < 8; k++) msgw[63-8*k -: 8] = MSG[k];
        feed1(1'b1, msgw, 8);
        chk("R8 u1 direct eight bytes", crc1, model(1'b1, msgw, 64));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule